// File: doc/BRIEF.md
# Sticky Reset Cause Status Register

This block keeps a 32-bit software-visible record of which reset sources have fired since software last cleared it. Seven cause lines feed it, all synchronous to the register clock and sampled on every edge:

- external hard reset
- external soft reset
- software watchdog expiry
- core checkstop, which counts only while its separate enable input is high
- debug-port hard reset request
- debug-port soft reset request
- test-access-port reset

Each cause owns one flag. A flag latches when its cause is seen. It stays latched until software writes a one to its bit position.

An active-low power-on reset loads the register. The two external-reset flags come up set and the others come up clear, so software can tell a cold start from a later warm reset. Address decode is done upstream. The block sees only a write strobe with write data, and a read strobe. While the read strobe is high, the current image appears combinationally on the read bus.

Each flag is a two-state machine:

- States: `CELL_CLEAR` (cause not recorded) and `CELL_LATCHED` (cause recorded).
- Transition *capture*: `CELL_CLEAR` to `CELL_LATCHED` on a qualified event.
- Transition *acknowledge*: `CELL_LATCHED` to `CELL_CLEAR` on a write-one with no event in that cycle.
- Transition *hold*: the state is kept in every other case.
- A qualified event in `CELL_LATCHED` keeps the flag latched, even when a clear arrives in the same cycle.

Top module: `rst_cause_status`

## Requirements
- R1: Bit positions in the read word are fixed, with bit 31 the most significant:
  - data bit 31: external hard reset flag
  - data bit 30: external soft reset flag
  - data bit 28: watchdog flag
  - data bit 27: checkstop flag
  - data bit 26: debug hard flag
  - data bit 25: debug soft flag
  - data bit 24: test-access-port reset flag
- R2: While `por_n` is low, and on the first cycles after it rises, the register reads 0xC000_0000. The external hard and soft flags are set and all other flags are clear.
- R3: A cause line high at a rising clock edge sets its flag at that edge. The flag then stays set on later edges with no event and no clear.
- R4: The checkstop flag sets only when `core_checkstop` and `checkstop_rst_en` are both high at the same edge. A checkstop without the enable leaves the flag at 0.
- R5: A write with a one in a flag's bit position clears that flag at the same edge. A zero in that position leaves the flag unchanged.
- R6: If a cause event and a clearing write hit the same flag in the same cycle, the flag ends set.
- R7: A cause line held high keeps its flag set across repeated clearing writes. The flag clears only on a write after the line has dropped.
- R8: Data bits 29 and 23 to 0 always read as 0, including after writes of all ones.
- R9: While `rd_en` is high, `rd_data` shows the current register image in the same cycle. While `rd_en` is low, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_hard_evt | input | 1 | External hard reset event |
| ext_soft_evt | input | 1 | External soft reset event |
| wdog_expire_evt | input | 1 | Software watchdog expiry event |
| core_checkstop | input | 1 | Core is in the checkstop state |
| checkstop_rst_en | input | 1 | Enable for checkstop-caused reset |
| dbg_hard_req | input | 1 | Debug-port hard reset request |
| dbg_soft_req | input | 1 | Debug-port soft reset request |
| tap_reset_evt | input | 1 | Test-access-port reset event |
| wr_en | input | 1 | Register write strobe (address already decoded) |
| wr_data | input | 32 | Write data; ones clear flags |
| rd_en | input | 1 | Register read strobe (address already decoded) |
| rd_data | output | 32 | Read data, combinational while `rd_en` is high |

## Verification
The bench sweeps all 256 combinations of the eight cause and enable inputs. Each combination is paired with a different clear mask, and the result is compared against an arithmetic model of the register.

The sweep exposes four kinds of fault:
- a swapped bit position;
- a checkstop that latches without its enable;
- a clear that beats a simultaneous event, which would silently lose a reset cause;
- a write-zero that disturbs a flag.

Directed steps then hold a cause high across several clearing writes, write all ones to prove the reserved bits stay zero, and pulse the power-on reset mid-run. A design that resets all flags to zero fails that last step, because it would report no cold start.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int DATA_W  = 32;
    localparam int NCAUSE  = 7;
    localparam int CHK_IDX = 3;

    typedef enum logic {
        CELL_CLEAR   = 1'b0,
        CELL_LATCHED = 1'b1
    } cell_state_e;

    // Big-endian position (0 = MSB): cause 0,1 at 0,1; position 2 reserved; others follow.
    function automatic int cause_pos(input int idx);
        return (idx < 2) ? idx : idx + 1;
    endfunction

    function automatic int cause_bit(input int idx);
        return DATA_W - 1 - cause_pos(idx);
    endfunction

    function automatic logic por_value(input int idx);
        return (idx < 2) ? 1'b1 : 1'b0;
    endfunction
endpackage

// File: rtl/rsc_cell.sv
module rsc_cell #(
    parameter logic POR_LATCHED = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    import rsc_pkg::*;

    cell_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= POR_LATCHED ? CELL_LATCHED : CELL_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: capture, acknowledge, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_CLEAR: begin
                if (evt) state_d = CELL_LATCHED;
            end
            CELL_LATCHED: begin
                if (!evt && clr) state_d = CELL_CLEAR;
            end
            default: state_d = CELL_CLEAR;
        endcase
    end

    // Output process
    always_comb begin
        flag = (state_q == CELL_LATCHED);
    end

    // R3
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
        evt |=> flag);

    // R6
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        (evt && clr) |=> flag);

    // R5
    clear_acts_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!evt && clr) |=> !flag);

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!evt && !clr) |=> $stable(flag));
endmodule

// File: rtl/rsc_capture.sv
module rsc_capture
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic [NCAUSE-1:0] raw_evt,
    input  logic              chk_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NCAUSE-1:0] flags
);
    logic [NCAUSE-1:0] qual_evt;
    logic [NCAUSE-1:0] clr_req;

    for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
        if (i == CHK_IDX) begin : g_gated
            assign qual_evt[i] = raw_evt[i] & chk_en;
        end else begin : g_plain
            assign qual_evt[i] = raw_evt[i];
        end

        assign clr_req[i] = wr_en & wr_data[cause_bit(i)];

        rsc_cell #(
            .POR_LATCHED(por_value(i))
        ) u_cell (
            .clk  (clk),
            .por_n(por_n),
            .evt  (qual_evt[i]),
            .clr  (clr_req[i]),
            .flag (flags[i])
        );
    end

    // R4
    chk_needs_enable_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!flags[CHK_IDX] && !(raw_evt[CHK_IDX] && chk_en)) |=> !flags[CHK_IDX]);
endmodule

// File: rtl/rsc_readport.sv
module rsc_readport
    import rsc_pkg::*;
(
    input  logic [NCAUSE-1:0] flags,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] image;

    always_comb begin
        image = '0;
        for (int i = 0; i < NCAUSE; i++) begin
            image[cause_bit(i)] = flags[i];
        end
    end

    assign rd_data = rd_en ? image : '0;
endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_hard_evt,
    input  logic              ext_soft_evt,
    input  logic              wdog_expire_evt,
    input  logic              core_checkstop,
    input  logic              checkstop_rst_en,
    input  logic              dbg_hard_req,
    input  logic              dbg_soft_req,
    input  logic              tap_reset_evt,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    logic [NCAUSE-1:0] raw_evt;
    logic [NCAUSE-1:0] flags;

    assign raw_evt = {tap_reset_evt, dbg_soft_req, dbg_hard_req, core_checkstop,
                      wdog_expire_evt, ext_soft_evt, ext_hard_evt};

    rsc_capture u_capture (
        .clk    (clk),
        .por_n  (por_n),
        .raw_evt(raw_evt),
        .chk_en (checkstop_rst_en),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .flags  (flags)
    );

    rsc_readport u_read (
        .flags  (flags),
        .rd_en  (rd_en),
        .rd_data(rd_data)
    );

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rd_data[29] == 1'b0) && (rd_data[23:0] == '0));

    // R9
    idle_bus_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rd_en |-> (rd_data == '0));

    // R1
    hard_pos_chk: assert property (@(posedge clk) disable iff (!por_n)
        rd_en |-> (rd_data[31] == flags[0]));

    // R7
    held_level_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ext_hard_evt && $past(ext_hard_evt)) |=> flags[0]);
endmodule

// File: tb/rst_cause_status_test.sv
module rst_cause_status_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VALID = 32'hDF00_0000;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [7:0]  ev = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b1;
    logic [31:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] model;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rst_cause_status uut (
        .clk             (clk),
        .por_n           (por_n),
        .ext_hard_evt    (ev[0]),
        .ext_soft_evt    (ev[1]),
        .wdog_expire_evt (ev[2]),
        .core_checkstop  (ev[3]),
        .checkstop_rst_en(ev[4]),
        .dbg_hard_req    (ev[5]),
        .dbg_soft_req    (ev[6]),
        .tap_reset_evt   (ev[7]),
        .wr_en           (wr_en),
        .wr_data         (wr_data),
        .rd_en           (rd_en),
        .rd_data         (rd_data)
    );

    function automatic logic [31:0] ev_image(input logic [7:0] e);
        logic [31:0] v = '0;
        v[31] = e[0];
        v[30] = e[1];
        v[28] = e[2];
        v[27] = e[3] & e[4];
        v[26] = e[5];
        v[25] = e[6];
        v[24] = e[7];
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    // Apply one cycle of events and optional write, then settle with inputs idle.
    task automatic step(input logic [7:0] e, input logic w, input logic [31:0] mask);
        @(negedge clk);
        ev = e; wr_en = w; wr_data = mask;
        @(negedge clk);
        ev = '0; wr_en = 1'b0; wr_data = '0;
        model = ((model & ~(w ? mask : 32'h0)) | ev_image(e)) & VALID;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        check("R2 value during por", rd_data, 32'hC000_0000);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        model = 32'hC000_0000;
        check("R2 value after por", rd_data, model);

        rd_en = 1'b0;
        #1;
        check("R9 idle bus", rd_data, 32'h0);
        rd_en = 1'b1;
        #1;
        check("R9 read shows image", rd_data, model);

        step(8'h00, 1'b1, 32'h0000_0000);
        check("R5 write zero no effect", rd_data, model);
        step(8'h00, 1'b1, 32'hFFFF_FFFF);
        check("R5 clear all", rd_data, 32'h0);

        step(8'h08, 1'b0, 32'h0);
        check("R4 checkstop without enable", rd_data, 32'h0);
        step(8'h18, 1'b0, 32'h0);
        check("R4 checkstop with enable", rd_data, 32'h0800_0000);

        step(8'h04, 1'b0, 32'h0);
        check("R1 watchdog bit 28", rd_data, 32'h1800_0000);
        step(8'h80, 1'b0, 32'h0);
        check("R1 tap bit 24", rd_data, 32'h1900_0000);
        step(8'h00, 1'b0, 32'h0);
        check("R3 sticky", rd_data, 32'h1900_0000);

        step(8'h04, 1'b1, 32'h1000_0000);
        check("R6 set beats clear", rd_data, 32'h1900_0000);

        step(8'h00, 1'b1, 32'hFFFF_FFFF);
        check("R8 reserved zero after all-ones write", rd_data, 32'h0);

        // R7: hold the debug hard request high across several clears.
        @(negedge clk);
        ev = 8'h20; wr_en = 1'b1; wr_data = 32'h0400_0000;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R7 held level stays set", rd_data, 32'h0400_0000);
        end
        ev = '0;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        check("R7 clears after level drops", rd_data, 32'h0);
        model = 32'h0;

        // Near-exhaustive sweep over all input combinations.
        for (int i = 0; i < 256; i++) begin
            logic [31:0] m;
            m = 32'h9E37_79B1 * (i + 1);
            step(i[7:0], i[0] ^ i[5], m);
            check("R3 R5 sweep", rd_data, model);
            check("R8 reserved sweep", rd_data & ~VALID, 32'h0);
        end

        // Power-on reset mid-run is asynchronous.
        step(8'hFF, 1'b0, 32'h0);
        #2;
        por_n = 1'b0;
        #1;
        check("R2 async por mid-run", rd_data, 32'hC000_0000);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check("R2 after por release", rd_data, 32'hC000_0000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule